// File: doc/BRIEF.md
# Synchronous Word Transmitter with Zero Stuffing

This block serialises data words onto a synchronous data-channel line. Words come from the read port of a small transmit queue that sits outside the block. When no word is waiting, the line carries a sync flag. When no word is waiting and the asynchronous front end has reported a line break, the line carries a break code instead. Inside data, a zero is inserted after every run of five ones, so that neither the flag nor the break code can appear in the middle of a data stream. During a long unbroken stream, a flag periodically takes the place of a data word so that the far end can keep its word alignment.

Bit timing comes from an external data clock, an output-enable input and a clock-mode input. All three are sampled by a fast system clock through two-stage synchronisers, and the block acts on the data-clock edges it detects. In the free-running mode, one bit is sent per falling data-clock edge for as long as the enable is high. In the framed mode, bits go out on rising edges, and at most eight bits are sent in each enable window. The line is three-stated through its enable output whenever the output enable is low or reset is asserted.

Top module: `sync_word_tx`

## Requirements
- R1: With no word ready and no break pending, the line sends the flag 0,1,1,1,1,1,1,0 in that order, and repeats it.
- R2: With no word ready and `brk_pend` high, the line sends the break code: seven ones and then a zero. A ready word takes precedence over a pending break.
- R3: In data words only, a 0 is sent after every run of five consecutive 1s. The run count carries across consecutive data words and restarts after any flag or break.
- R4: After 60 consecutive data words, the next pattern is a flag, and the waiting word is kept for the pattern after that flag.
- R5: With `cm_in` low, each falling `dc_in` edge while `doe_in` is high puts the next stream bit on `dco_out`. No bit advances while `doe_in` is low, and a window has no limit on its bit count. After reset, `dco_out` is 1 until the first advance.
- R6: With `cm_in` high, bits advance on rising `dc_in` edges while `doe_in` is high, at most eight per high window. Further edges hold the last bit, and a low `doe_in` restarts the count.
- R7: `dco_oe` is low whenever `doe_in` is low or `rst_n` is low.
- R8: After reset is released, flags are sent until a word is present at the queue head.
- R9: `len9` high sends 9-bit words from `fifo_data[8:0]`. `len9` low sends 8-bit words from `fifo_data[7:0]`. Data bits go least significant bit first.
- R10: `fifo_pop` pulses only at the advance where the previous pattern, including any stuffed zero, has been fully sent. A word that arrives mid-pattern waits for that boundary.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Fast system clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| dc_in | input | 1 | External data clock (asynchronous) |
| doe_in | input | 1 | Output enable (asynchronous) |
| cm_in | input | 1 | Clock mode: 0 free-running, 1 framed with eight-bit cap |
| len9 | input | 1 | Word length select: 1 means 9 bits, 0 means 8 bits |
| brk_pend | input | 1 | Break pending from the asynchronous front end |
| fifo_valid | input | 1 | Queue head holds a word |
| fifo_data | input | 9 | Word at the queue head |
| fifo_pop | output | 1 | One-cycle pulse that consumes the queue head |
| dco_out | output | 1 | Serial line data, valid while dco_oe is high |
| dco_oe | output | 1 | Line driver enable; low means high impedance |

## Verification
A stuck run counter or a wrong stuffing decision shows up directly at `dco_out`. A bit is added or dropped within a few bits of the first run of five ones, and every later bit is shifted by one place. An off-by-one in the periodic flag counter shifts the forced flag by one word, 61 words into a continuous stream. A pattern loaded too early shows as a truncated flag and an early `fifo_pop`. A window counter that fails to restart shows up as a framed window that freezes before its eighth bit or runs past it.

// File: rtl/sync_tx_pkg.sv
package sync_tx_pkg;

  typedef enum logic [1:0] {
    PK_FLAG  = 2'd0,
    PK_BREAK = 2'd1,
    PK_DATA  = 2'd2
  } pat_kind_e;

  // Patterns are held with bit 0 sent first.
  localparam int unsigned PAT_LEN = 8;

  function automatic logic [7:0] flag_pat();
    return 8'b0111_1110;
  endfunction

  function automatic logic [7:0] break_pat();
    // seven ones on the line, then a zero
    return 8'b0111_1111;
  endfunction

  // Pattern choice: a ready word wins unless a periodic flag is due;
  // break only when nothing is ready.
  function automatic pat_kind_e pick_kind(input logic word_rdy,
                                          input logic brk,
                                          input logic flag_due);
    if (word_rdy && !flag_due) return PK_DATA;
    if (!word_rdy && brk)      return PK_BREAK;
    return PK_FLAG;
  endfunction

endpackage

// File: rtl/sync_tx_sync.sv
module sync_tx_sync #(
  parameter int unsigned STAGES = 2
) (
  input  logic clk,
  input  logic rst_n,
  input  logic async_in,
  output logic lvl,
  output logic prev
);
  localparam int unsigned DEPTH = STAGES + 1;

  logic [DEPTH-1:0] pipe_q;

  genvar g;
  generate
    for (g = 0; g < DEPTH; g++) begin : g_stage
      always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) pipe_q[g] <= 1'b0;
        else if (g == 0) pipe_q[g] <= async_in;
        else pipe_q[g] <= pipe_q[(g == 0) ? 0 : g-1];
      end
    end
  endgenerate

  assign lvl  = pipe_q[STAGES-1];
  assign prev = pipe_q[STAGES];

endmodule

// File: rtl/sync_tx_pacer.sv
module sync_tx_pacer #(
  parameter int unsigned CAP = 8
) (
  input  logic clk,
  input  logic rst_n,
  input  logic dc_lvl,
  input  logic dc_prev,
  input  logic doe_lvl,
  input  logic doe_prev,
  input  logic cm_lvl,
  input  logic cm_prev,
  output logic adv
);
  localparam int unsigned CNT_W = $clog2(CAP + 1);

  logic             dc_rise, dc_fall, win_start, mode_flip, cap_hit;
  logic [CNT_W-1:0] cnt_q;

  assign dc_rise   = dc_lvl & ~dc_prev;
  assign dc_fall   = ~dc_lvl & dc_prev;
  assign win_start = doe_lvl & ~doe_prev;
  assign mode_flip = cm_lvl ^ cm_prev;
  assign cap_hit   = (cnt_q == CNT_W'(CAP));

  always_comb begin
    if (cm_lvl) adv = doe_lvl & dc_rise & ~cap_hit & ~mode_flip;
    else        adv = doe_lvl & dc_fall & ~mode_flip;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)                              cnt_q <= '0;
    else if (!doe_lvl || mode_flip)          cnt_q <= '0;
    else if (win_start && !adv)              cnt_q <= '0;
    else if (win_start && adv)               cnt_q <= CNT_W'(1);
    else if (adv && cm_lvl)                  cnt_q <= cnt_q + CNT_W'(1);
  end

endmodule

// File: rtl/sync_tx_framer.sv
module sync_tx_framer
  import sync_tx_pkg::*;
#(
  parameter int unsigned MAXW       = 9,
  parameter int unsigned RUN_LEN    = 5,
  parameter int unsigned FLAG_EVERY = 61
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic            adv,
  input  logic            len9,
  input  logic            brk_pend,
  input  logic            fifo_valid,
  input  logic [MAXW-1:0] fifo_data,
  output logic            fifo_pop,
  output logic            tx_bit
);
  localparam int unsigned CW = $clog2(MAXW + 1);
  localparam int unsigned OW = $clog2(RUN_LEN + 1);
  localparam int unsigned RW = $clog2(FLAG_EVERY);

  logic [MAXW-1:0] sh_q;
  logic [CW-1:0]   rem_q;
  pat_kind_e       kind_q;
  logic [OW-1:0]   ones_q;
  logic [RW-1:0]   run_q;
  logic            tx_q;

  logic            stuff_now, empty, flag_due, load_evt;
  pat_kind_e       nk;
  logic [MAXW-1:0] npat;
  logic [CW-1:0]   nlen;

  assign stuff_now = (kind_q == PK_DATA) && (ones_q == OW'(RUN_LEN));
  assign empty     = (rem_q == '0) && !stuff_now;
  assign flag_due  = (run_q == RW'(FLAG_EVERY - 1));
  assign nk        = pick_kind(fifo_valid, brk_pend, flag_due);

  always_comb begin
    case (nk)
      PK_DATA: begin
        npat = len9 ? fifo_data : {1'b0, fifo_data[MAXW-2:0]};
        nlen = len9 ? CW'(MAXW) : CW'(MAXW - 1);
      end
      PK_BREAK: begin
        npat = {{(MAXW-PAT_LEN){1'b0}}, break_pat()};
        nlen = CW'(PAT_LEN);
      end
      default: begin
        npat = {{(MAXW-PAT_LEN){1'b0}}, flag_pat()};
        nlen = CW'(PAT_LEN);
      end
    endcase
  end

  assign load_evt = adv & empty;
  assign fifo_pop = load_evt & (nk == PK_DATA);
  assign tx_bit   = tx_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      sh_q   <= '0;
      rem_q  <= '0;
      kind_q <= PK_FLAG;
      ones_q <= '0;
      run_q  <= '0;
      tx_q   <= 1'b1;
    end else if (adv) begin
      if (empty) begin
        tx_q   <= npat[0];
        sh_q   <= npat >> 1;
        rem_q  <= nlen - CW'(1);
        kind_q <= nk;
        ones_q <= (nk == PK_DATA && npat[0]) ? ones_q + OW'(1) : '0;
        run_q  <= (nk == PK_DATA) ? run_q + RW'(1) : '0;
      end else if (stuff_now) begin
        tx_q   <= 1'b0;
        ones_q <= '0;
      end else begin
        tx_q   <= sh_q[0];
        sh_q   <= sh_q >> 1;
        rem_q  <= rem_q - CW'(1);
        ones_q <= (kind_q == PK_DATA && sh_q[0]) ? ones_q + OW'(1) : '0;
      end
    end
  end

  // R10: a word is consumed only when present and only on a bit advance
  a_r10_pop_valid: assert property (@(posedge clk) disable iff (!rst_n)
    fifo_pop |-> fifo_valid);
  a_r10_pop_on_adv: assert property (@(posedge clk) disable iff (!rst_n)
    fifo_pop |-> adv);
  // R3: a full run of ones inside data is followed by a zero on the line
  a_r3_stuff_zero: assert property (@(posedge clk) disable iff (!rst_n)
    (adv && kind_q == PK_DATA && ones_q == OW'(RUN_LEN)) |=> !tx_bit);
  // R4: the consecutive-word count never passes the forced-flag point
  a_r4_run_bound: assert property (@(posedge clk) disable iff (!rst_n)
    run_q < RW'(FLAG_EVERY));

endmodule

// File: rtl/sync_word_tx.sv
module sync_word_tx #(
  parameter int unsigned MAXW       = 9,
  parameter int unsigned RUN_LEN    = 5,
  parameter int unsigned FLAG_EVERY = 61,
  parameter int unsigned CAP        = 8,
  parameter int unsigned SYNC_STG   = 2
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic            dc_in,
  input  logic            doe_in,
  input  logic            cm_in,
  input  logic            len9,
  input  logic            brk_pend,
  input  logic            fifo_valid,
  input  logic [MAXW-1:0] fifo_data,
  output logic            fifo_pop,
  output logic            dco_out,
  output logic            dco_oe
);
  localparam int unsigned WC_W = $clog2(CAP + 2);

  logic dc_lvl, dc_prev, doe_lvl, doe_prev, cm_lvl, cm_prev;
  logic adv, tx_bit;

  sync_tx_sync #(.STAGES(SYNC_STG)) u_dc_sync (
    .clk(clk), .rst_n(rst_n), .async_in(dc_in), .lvl(dc_lvl), .prev(dc_prev));
  sync_tx_sync #(.STAGES(SYNC_STG)) u_doe_sync (
    .clk(clk), .rst_n(rst_n), .async_in(doe_in), .lvl(doe_lvl), .prev(doe_prev));
  sync_tx_sync #(.STAGES(SYNC_STG)) u_cm_sync (
    .clk(clk), .rst_n(rst_n), .async_in(cm_in), .lvl(cm_lvl), .prev(cm_prev));

  sync_tx_pacer #(.CAP(CAP)) u_pacer (
    .clk(clk), .rst_n(rst_n),
    .dc_lvl(dc_lvl), .dc_prev(dc_prev),
    .doe_lvl(doe_lvl), .doe_prev(doe_prev),
    .cm_lvl(cm_lvl), .cm_prev(cm_prev),
    .adv(adv));

  sync_tx_framer #(.MAXW(MAXW), .RUN_LEN(RUN_LEN), .FLAG_EVERY(FLAG_EVERY)) u_framer (
    .clk(clk), .rst_n(rst_n), .adv(adv), .len9(len9), .brk_pend(brk_pend),
    .fifo_valid(fifo_valid), .fifo_data(fifo_data),
    .fifo_pop(fifo_pop), .tx_bit(tx_bit));

  assign dco_out = tx_bit;
  assign dco_oe  = rst_n & doe_lvl;

  // Checker count of advances inside one enable window
  logic [WC_W-1:0] win_adv_q;
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)        win_adv_q <= '0;
    else if (!doe_lvl) win_adv_q <= '0;
    else if (adv && win_adv_q != WC_W'(CAP + 1)) win_adv_q <= win_adv_q + WC_W'(1);
  end

  // R6: framed mode never advances past the cap within a window
  a_r6_cap8: assert property (@(posedge clk) disable iff (!rst_n)
    (cm_lvl && cm_prev && doe_prev && adv) |-> (win_adv_q < WC_W'(CAP)));
  // R5: with the driver disabled the line bit does not move
  a_r5_hold: assert property (@(posedge clk) disable iff (!rst_n)
    !dco_oe |=> $stable(dco_out));

endmodule

// File: tb/sync_word_tx_bench.sv
`timescale 1ns/1ps
module sync_word_tx_bench;
  localparam int H = 5;

  logic clk = 1'b0;
  always #5 clk = ~clk;

  logic rst_n = 1'b0, dc = 1'b1, doe = 1'b0, cm = 1'b0, len9 = 1'b0, brk = 1'b0;
  logic fifo_valid, fifo_pop, dco_out, dco_oe;
  logic [8:0] fifo_data;

  logic [8:0] fq [0:255];
  int wr = 0, rd = 0;
  logic fq_clr = 1'b1;
  assign fifo_valid = (rd < wr);
  assign fifo_data  = fq[rd[7:0]];
  always @(posedge clk) begin
    if (fq_clr) rd <= 0;
    else if (fifo_pop) rd <= rd + 1;
  end

  sync_word_tx u_sync_word_tx (
    .clk(clk), .rst_n(rst_n), .dc_in(dc), .doe_in(doe), .cm_in(cm),
    .len9(len9), .brk_pend(brk), .fifo_valid(fifo_valid), .fifo_data(fifo_data),
    .fifo_pop(fifo_pop), .dco_out(dco_out), .dco_oe(dco_oe));

  int n_chk = 0, n_bad = 0;
  bit done = 0;

  logic exp_b [0:2047];
  int   exp_n = 0;
  int   run1 = 0;

  task automatic check(input bit ok, input string req, input string what,
                       input int act, input int expv);
    n_chk++;
    if (!ok) begin
      n_bad++;
      $display("FAIL %s %s: actual %0d expected %0d", req, what, act, expv);
    end
  endtask

  // independent encoder of the expected line stream
  task automatic enc_raw(input logic b);
    exp_b[exp_n] = b;
    exp_n++;
  endtask
  task automatic enc_word(input logic [8:0] w, input int len);
    for (int i = 0; i < len; i++) begin
      enc_raw(w[i]);
      if (w[i]) run1++; else run1 = 0;
      if (run1 == 5) begin enc_raw(1'b0); run1 = 0; end
    end
  endtask
  task automatic enc_flag();
    logic [7:0] f = 8'b0111_1110;
    for (int i = 0; i < 8; i++) enc_raw(f[i]);
    run1 = 0;
  endtask
  task automatic enc_break();
    for (int i = 0; i < 7; i++) enc_raw(1'b1);
    enc_raw(1'b0);
    run1 = 0;
  endtask

  task automatic push(input logic [8:0] w);
    fq[wr[7:0]] = w;
    wr++;
  endtask

  task automatic clk_bit(output logic b);
    if (!cm) begin
      @(negedge clk) dc = 1'b0;
      repeat (H) @(negedge clk);
      b = dco_out; dc = 1'b1;
      repeat (H) @(negedge clk);
    end else begin
      @(negedge clk) dc = 1'b1;
      repeat (H) @(negedge clk);
      b = dco_out; dc = 1'b0;
      repeat (H) @(negedge clk);
    end
  endtask

  task automatic cmp_range(input int from, input int to, input string req, input string what);
    int bad = 0, first = -1;
    logic fa = 1'b0, fe = 1'b0;
    for (int i = from; i < to; i++) begin
      logic b;
      clk_bit(b);
      if (b !== exp_b[i]) begin
        if (first < 0) begin first = i; fa = b; fe = exp_b[i]; end
        bad++;
      end
    end
    check(bad == 0, req, $sformatf("%s first bad bit %0d", what, first), int'(fa), int'(fe));
  endtask

  task automatic do_reset(input logic mode);
    @(negedge clk);
    rst_n = 1'b0; cm = mode; dc = mode ? 1'b0 : 1'b1; doe = 1'b1;
    brk = 1'b0; len9 = 1'b0; fq_clr = 1'b1; wr = 0;
    exp_n = 0; run1 = 0;
    repeat (4) @(negedge clk);
    check(dco_oe == 1'b0, "R7", "oe in reset", int'(dco_oe), 0);
    check(fifo_pop == 1'b0, "R10", "pop in reset", int'(fifo_pop), 0);
    rst_n = 1'b1; fq_clr = 1'b0;
    repeat (4) @(negedge clk);
  endtask

  task automatic t_idle_flags();
    do_reset(1'b0);
    check(dco_oe == 1'b1, "R7", "oe enabled", int'(dco_oe), 1);
    check(dco_out == 1'b1, "R5", "line before first advance", int'(dco_out), 1);
    enc_flag(); enc_flag(); enc_flag();
    cmp_range(0, 24, "R1", "idle flags after reset R8");
  endtask

  task automatic t_break();
    do_reset(1'b0);
    brk = 1'b1;
    enc_break(); enc_break();
    cmp_range(0, 16, "R2", "break code");
    push(9'h000);
    enc_word(9'h000, 8); enc_break();
    cmp_range(16, 32, "R2", "word before break");
  endtask

  task automatic t_stuff8();
    logic [8:0] ws [5] = '{9'h0FF, 9'h01F, 9'h03E, 9'h000, 9'h0F0};
    do_reset(1'b0);
    foreach (ws[i]) begin push(ws[i]); enc_word(ws[i], 8); end
    enc_flag(); enc_flag();
    cmp_range(0, exp_n, "R3", "stuffed 8-bit stream R9");
    check(rd == 5, "R10", "words consumed", rd, 5);
  endtask

  task automatic t_word9();
    logic [8:0] ws [3] = '{9'h1FF, 9'h155, 9'h100};
    do_reset(1'b0);
    len9 = 1'b1;
    foreach (ws[i]) begin push(ws[i]); enc_word(ws[i], 9); end
    enc_flag();
    cmp_range(0, exp_n, "R9", "9-bit stream");
  endtask

  task automatic t_flag61();
    do_reset(1'b0);
    for (int i = 0; i < 130; i++) begin
      push(9'h055);
      if (i == 60 || i == 120) enc_flag();
      enc_word(9'h055, 8);
    end
    enc_flag(); enc_flag();
    cmp_range(0, exp_n, "R4", "forced flag every 61st");
    check(rd == 130, "R4", "all words kept and sent", rd, 130);
  endtask

  task automatic t_midpush();
    do_reset(1'b0);
    enc_flag(); enc_word(9'h0A5, 8); enc_flag();
    cmp_range(0, 3, "R10", "flag head");
    push(9'h0A5);
    cmp_range(3, 5, "R10", "flag middle");
    check(rd == 0, "R10", "no pop mid-pattern", rd, 0);
    cmp_range(5, exp_n, "R10", "word after flag boundary");
  endtask

  task automatic t_doe_gap();
    do_reset(1'b0);
    push(9'h00F); push(9'h0F0);
    enc_word(9'h00F, 8); enc_word(9'h0F0, 8); enc_flag();
    cmp_range(0, 5, "R5", "before gap");
    @(negedge clk) doe = 1'b0;
    for (int i = 0; i < 3; i++) begin logic b; clk_bit(b); end
    check(dco_oe == 1'b0, "R7", "oe with doe low", int'(dco_oe), 0);
    @(negedge clk) doe = 1'b1;
    repeat (H) @(negedge clk);
    cmp_range(5, exp_n, "R5", "after gap no bit lost");
  endtask

  task automatic t_framed();
    int bad = 0;
    do_reset(1'b1);
    @(negedge clk) doe = 1'b0;
    repeat (H) @(negedge clk);
    push(9'h055); push(9'h033); push(9'h0C3);
    enc_word(9'h055, 8); enc_word(9'h033, 8); enc_word(9'h0C3, 8);
    @(negedge clk) doe = 1'b1;
    repeat (2) @(negedge clk);
    cmp_range(0, 8, "R6", "first window");
    for (int i = 0; i < 4; i++) begin
      logic b; clk_bit(b);
      if (b !== exp_b[7]) bad++;
    end
    check(bad == 0, "R6", "held last bit after cap", bad, 0);
    @(negedge clk) doe = 1'b0;
    repeat (H) @(negedge clk);
    check(dco_oe == 1'b0, "R7", "oe between windows", int'(dco_oe), 0);
    doe = 1'b1;
    repeat (2) @(negedge clk);
    cmp_range(8, 16, "R6", "second window restarts count");
  endtask

  initial begin
    repeat (3) @(negedge clk);
    t_idle_flags();
    t_break();
    t_stuff8();
    t_word9();
    t_flag61();
    t_midpush();
    t_doe_gap();
    t_framed();
    done = 1;
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      n_chk++; n_bad++;
      $display("FAIL watchdog: actual %0d expected %0d", 0, 1);
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
      $finish;
    end
  end

endmodule